// File: doc/BRIEF.md
# Generation-bit transmit descriptor consumer

This block walks a host-written transmit descriptor ring and turns runs of descriptors into packets. The host fills ring slots and then advances a producer index. The consumer reads every slot below that index through a one-cycle-latency read port. It takes a slot only when the slot's ownership bit equals the consumer's current lap value. That value starts at 1 after reset and toggles each time the consumer index wraps to zero.

Descriptors are collected until one carries the end-of-packet flag. The block then emits a one-cycle packet summary: first slot index, descriptor count and summed byte length. If the closing descriptor asks for it, the block also writes a four-dword completion record into a separate completion ring, which has its own index and lap bit.

Two kinds of malformed packet halt the queue: too many descriptors in one packet, or a chain that breaks before its closing flag. A halted queue shows a stopped flag and a 32-bit error code. It ignores the host until reset.

Top module: `txc_consumer`

## Requirements
- R1: After reset no read, packet summary or completion write is issued, `q_stopped` is 0 and `q_err` is 0; the consumer and completion indices start at 0.
- R2: A descriptor word carries the length in bits 13:0, the ownership bit in bit 14, end-of-packet in bit 15 and completion-request in bit 16; a descriptor is consumed only when bit 14 equals the consumer lap value.
- R3: The consumer only reads slots strictly below the producer index. A packet that has no closing descriptor yet waits, with no summary and no error, until the host publishes more slots.
- R4: On the closing descriptor, `pkt_valid` pulses for one cycle with the packet's first slot index, its descriptor count, and the sum of its lengths, where a length field of 0 counts as 16384 bytes.
- R5: The consumer lap value is 1 after reset and toggles whenever the consumer index wraps from `tx_ring_size`-1 to 0, so the next lap's descriptors must carry ownership bit 0.
- R6: A completion record is written only when the closing descriptor has the completion-request bit set. Its bits 11:0 hold the closing descriptor's slot index, bits 126:120 (type) are 0, bit 127 is the completion lap bit, and all other bits are 0. `cmp_addr` is the completion ring index.
- R7: The completion index advances once per record and wraps from `cmp_ring_size`-1 to 0. Its lap bit starts at 1 and toggles on each wrap.
- R8: A packet may span up to MAX_DESC (16) descriptors. When the MAX_DESC-th descriptor of a packet lacks end-of-packet, the queue halts with `q_err` = 0x80000002 and emits no summary.
- R9: When a packet is open and the next published slot's ownership bit does not match the lap value, the queue halts with `q_err` = 0x80000000 and emits no summary.
- R10: Once halted, `q_stopped` stays 1, producer updates are ignored, and no read, summary or completion write occurs until reset.
- R11: A published slot with a non-matching ownership bit while no packet is open is not an error; the consumer polls it until the host rewrites it with the right ownership bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, also clears a halted queue |
| tx_ring_size | input | 13 | Descriptor ring entries (multiple of 32) |
| cmp_ring_size | input | 13 | Completion ring entries (multiple of 32) |
| prod_we | input | 1 | Producer index update strobe |
| prod_idx | input | 12 | New producer index |
| rd_en | output | 1 | Descriptor read request |
| rd_addr | output | 12 | Descriptor slot to read |
| rd_data | input | 17 | Descriptor word, valid the cycle after `rd_en` |
| pkt_valid | output | 1 | Packet summary strobe |
| pkt_start | output | 12 | First slot of the packet |
| pkt_cnt | output | 5 | Descriptors in the packet |
| pkt_len | output | 19 | Total packet bytes |
| cmp_we | output | 1 | Completion record write strobe |
| cmp_addr | output | 12 | Completion ring slot |
| cmp_data | output | 128 | Completion record |
| q_stopped | output | 1 | Queue halted |
| q_err | output | 32 | Halt reason code |

## Verification
The bench builds the block with MAX_RING = 64, and programs a 32-entry descriptor ring and a 64-entry completion ring. With these sizes, a run of about ninety short packets wraps the descriptor ring several times and the completion ring at least once. That exercises both lap-bit toggles and the ring-size inputs being different. MAX_DESC keeps its default of 16, so a packet at exactly the limit and one just past it both fit inside a single 32-slot lap.

// File: rtl/txc_pkg.sv
package txc_pkg;
   // descriptor word layout
   localparam int DLEN_W   = 14;
   localparam int D_GEN    = 14;
   localparam int D_EOP    = 15;
   localparam int D_CQ     = 16;
   localparam int DESC_W   = 17;
   localparam int CMP_W    = 128;
   localparam int CIDX_W   = 12;
   localparam int MAX_BUF  = 16384;

   localparam logic [31:0] ERR_NO_END  = 32'h8000_0000;
   localparam logic [31:0] ERR_TOO_BIG = 32'h8000_0002;
   localparam logic [6:0]  CTYPE_TX    = 7'd0;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_HALT
   } txc_state_e;

   typedef struct packed {
      logic              cq;
      logic              eop;
      logic              gen;
      logic [DLEN_W-1:0] len;
   } txc_desc_t;

   function automatic txc_desc_t txc_decode(input logic [DESC_W-1:0] w);
      txc_desc_t d;
      d.len = w[DLEN_W-1:0];
      d.gen = w[D_GEN];
      d.eop = w[D_EOP];
      d.cq  = w[D_CQ];
      return d;
   endfunction

   function automatic logic [CMP_W-1:0] txc_cmp_rec(input logic [CIDX_W-1:0] idx,
                                                    input logic gen);
      return {gen, CTYPE_TX, 24'd0, 64'd0, 20'd0, idx};
   endfunction
endpackage

// File: rtl/txc_ring_ptr.sv
module txc_ring_ptr #(
   parameter int IDX_W  = 12,
   parameter int SIZE_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [SIZE_W-1:0] size,
   output logic [IDX_W-1:0]  idx,
   output logic              gen
);
   logic at_last;

   assign at_last = ({1'b0, idx} == (size - SIZE_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
         gen <= 1'b1;
      end else if (adv) begin
         if (at_last) begin
            idx <= '0;
            gen <= ~gen;
         end else begin
            idx <= idx + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/txc_pkt_acc.sv
module txc_pkt_acc import txc_pkg::*; #(
   parameter int IDX_W       = 12,
   parameter int CNT_W       = 5,
   parameter int TOT_W       = 19,
   parameter bit ZERO_IS_MAX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              add,
   input  logic              clr,
   input  logic [IDX_W-1:0]  idx_in,
   input  logic [DLEN_W-1:0] len_in,
   output logic [CNT_W-1:0]  nxt_cnt,
   output logic [TOT_W-1:0]  nxt_total,
   output logic [IDX_W-1:0]  start_sel,
   output logic              open
);
   logic [CNT_W-1:0] cnt;
   logic [TOT_W-1:0] total;
   logic [IDX_W-1:0] start;
   logic [TOT_W-1:0] eff;

   generate
      if (ZERO_IS_MAX) begin : g_zero_max
         assign eff = (len_in == '0) ? TOT_W'(MAX_BUF) : TOT_W'(len_in);
      end else begin : g_zero_raw
         assign eff = TOT_W'(len_in);
      end
   endgenerate

   assign nxt_cnt   = cnt + CNT_W'(1);
   assign nxt_total = total + eff;
   assign start_sel = (cnt == '0) ? idx_in : start;
   assign open      = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt   <= '0;
         total <= '0;
         start <= '0;
      end else if (add) begin
         cnt   <= nxt_cnt;
         total <= nxt_total;
         start <= start_sel;
      end
   end
endmodule

// File: rtl/txc_consumer.sv
module txc_consumer import txc_pkg::*; #(
   parameter int  MAX_RING    = 4096,
   parameter int  MAX_DESC    = 16,
   parameter bit  ZERO_IS_MAX = 1'b1,
   localparam int IDX_W       = $clog2(MAX_RING),
   localparam int SIZE_W      = IDX_W + 1,
   localparam int CNT_W       = $clog2(MAX_DESC + 1),
   localparam int TOT_W       = DLEN_W + 1 + $clog2(MAX_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SIZE_W-1:0] tx_ring_size,
   input  logic [SIZE_W-1:0] cmp_ring_size,
   input  logic              prod_we,
   input  logic [IDX_W-1:0]  prod_idx,
   output logic              rd_en,
   output logic [IDX_W-1:0]  rd_addr,
   input  logic [DESC_W-1:0] rd_data,
   output logic              pkt_valid,
   output logic [IDX_W-1:0]  pkt_start,
   output logic [CNT_W-1:0]  pkt_cnt,
   output logic [TOT_W-1:0]  pkt_len,
   output logic              cmp_we,
   output logic [IDX_W-1:0]  cmp_addr,
   output logic [CMP_W-1:0]  cmp_data,
   output logic              q_stopped,
   output logic [31:0]       q_err
);
   generate
      if (MAX_RING < 32 || MAX_RING > 4096 || (MAX_RING % 32) != 0) begin : g_bad_ring
         $error("MAX_RING must be a multiple of 32 between 32 and 4096");
      end
      if (MAX_DESC < 2 || MAX_DESC > MAX_RING) begin : g_bad_desc
         $error("MAX_DESC must lie between 2 and MAX_RING");
      end
      if (IDX_W > CIDX_W) begin : g_bad_idx
         $error("slot index does not fit the completion index field");
      end
   endgenerate

   txc_state_e       state, state_nxt;
   logic [IDX_W-1:0] prod_q;
   logic [IDX_W-1:0] cons_idx, cmp_idx;
   logic             cons_gen, cmp_gen;
   txc_desc_t        d;
   logic             in_eval, owned, accept, done, err_big, err_noeop;
   logic             cons_adv, acc_add, cmp_adv;
   logic [CNT_W-1:0] nxt_cnt;
   logic [TOT_W-1:0] nxt_total;
   logic [IDX_W-1:0] start_sel;
   logic             open;

   always_comb begin
      d         = txc_decode(rd_data);
      rd_en     = (state == ST_IDLE) && (cons_idx != prod_q);
      rd_addr   = cons_idx;
      in_eval   = (state == ST_FETCH);
      owned     = (d.gen == cons_gen);
      accept    = in_eval && owned;
      err_noeop = in_eval && !owned && open;
      done      = accept && d.eop;
      err_big   = accept && !d.eop && (nxt_cnt == CNT_W'(MAX_DESC));
      cons_adv  = accept && !err_big;
      acc_add   = accept && !d.eop && !err_big;
      cmp_adv   = done && d.cq;
      q_stopped = (state == ST_HALT);
   end

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:  if (rd_en) state_nxt = ST_FETCH;
         ST_FETCH: state_nxt = (err_big || err_noeop) ? ST_HALT : ST_IDLE;
         default:  state_nxt = ST_HALT;
      endcase
   end

   txc_ring_ptr #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_cons_ptr (
      .clk(clk), .rst_n(rst_n), .adv(cons_adv), .size(tx_ring_size),
      .idx(cons_idx), .gen(cons_gen)
   );

   txc_ring_ptr #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_cmp_ptr (
      .clk(clk), .rst_n(rst_n), .adv(cmp_adv), .size(cmp_ring_size),
      .idx(cmp_idx), .gen(cmp_gen)
   );

   txc_pkt_acc #(.IDX_W(IDX_W), .CNT_W(CNT_W), .TOT_W(TOT_W),
                 .ZERO_IS_MAX(ZERO_IS_MAX)) u_acc (
      .clk(clk), .rst_n(rst_n), .add(acc_add), .clr(done),
      .idx_in(cons_idx), .len_in(d.len),
      .nxt_cnt(nxt_cnt), .nxt_total(nxt_total), .start_sel(start_sel), .open(open)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         prod_q    <= '0;
         q_err     <= '0;
         pkt_valid <= 1'b0;
         pkt_start <= '0;
         pkt_cnt   <= '0;
         pkt_len   <= '0;
         cmp_we    <= 1'b0;
         cmp_addr  <= '0;
         cmp_data  <= '0;
      end else begin
         state     <= state_nxt;
         pkt_valid <= done;
         cmp_we    <= cmp_adv;
         if (prod_we && state != ST_HALT) prod_q <= prod_idx;
         if (err_big)   q_err <= ERR_TOO_BIG;
         if (err_noeop) q_err <= ERR_NO_END;
         if (done) begin
            pkt_start <= start_sel;
            pkt_cnt   <= nxt_cnt;
            pkt_len   <= nxt_total;
         end
         if (cmp_adv) begin
            cmp_addr <= cmp_idx;
            cmp_data <= txc_cmp_rec(CIDX_W'(cons_idx), cmp_gen);
         end
      end
   end
endmodule

// File: rtl/txc_consumer_chk.sv
module txc_consumer_chk import txc_pkg::*; #(
   parameter int  MAX_RING = 4096,
   parameter int  MAX_DESC = 16,
   localparam int IDX_W    = $clog2(MAX_RING),
   localparam int CNT_W    = $clog2(MAX_DESC + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic [IDX_W-1:0] rd_addr,
   input logic [IDX_W-1:0] prod_q,
   input logic             pkt_valid,
   input logic [CNT_W-1:0] pkt_cnt,
   input logic             cmp_we,
   input logic [CMP_W-1:0] cmp_data,
   input logic             q_stopped,
   input logic [31:0]      q_err
);
   AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !q_stopped |-> (q_err == 32'd0)); // R1
   AST_READ_BELOW_PROD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr != prod_q)); // R3
   AST_CMP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_we |-> (cmp_data[126:120] == 7'd0 && cmp_data[119:12] == '0)); // R6
   AST_PKT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_cnt != '0 && pkt_cnt <= CNT_W'(MAX_DESC))); // R8
   AST_HALT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      q_stopped |-> (q_err == ERR_TOO_BIG || q_err == ERR_NO_END)); // R9
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      q_stopped |=> (q_stopped && $stable(q_err))); // R10
   AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      q_stopped |-> (!rd_en && !pkt_valid && !cmp_we)); // R10
endmodule

bind txc_consumer txc_consumer_chk #(.MAX_RING(MAX_RING), .MAX_DESC(MAX_DESC)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .prod_q(prod_q),
   .pkt_valid(pkt_valid), .pkt_cnt(pkt_cnt), .cmp_we(cmp_we), .cmp_data(cmp_data),
   .q_stopped(q_stopped), .q_err(q_err)
);

// File: tb/txc_consumer_tb_top.sv
module txc_consumer_tb_top;
   localparam int MR     = 64;
   localparam int MD     = 16;
   localparam int IDX_W  = $clog2(MR);
   localparam int SIZE_W = IDX_W + 1;
   localparam int CNT_W  = $clog2(MD + 1);
   localparam int TOT_W  = 14 + 1 + $clog2(MD);
   localparam int TXR    = 32;
   localparam int CMR    = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prod_we = 1'b0;
   logic [IDX_W-1:0]  prod_idx = '0;
   logic              rd_en;
   logic [IDX_W-1:0]  rd_addr;
   logic [16:0]       rd_data = '0;
   logic              pkt_valid;
   logic [IDX_W-1:0]  pkt_start;
   logic [CNT_W-1:0]  pkt_cnt;
   logic [TOT_W-1:0]  pkt_len;
   logic              cmp_we;
   logic [IDX_W-1:0]  cmp_addr;
   logic [127:0]      cmp_data;
   logic              q_stopped;
   logic [31:0]       q_err;

   always #10 clk = ~clk;

   txc_consumer #(.MAX_RING(MR), .MAX_DESC(MD)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .tx_ring_size(SIZE_W'(TXR)), .cmp_ring_size(SIZE_W'(CMR)),
      .prod_we(prod_we), .prod_idx(prod_idx),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .pkt_valid(pkt_valid), .pkt_start(pkt_start), .pkt_cnt(pkt_cnt), .pkt_len(pkt_len),
      .cmp_we(cmp_we), .cmp_addr(cmp_addr), .cmp_data(cmp_data),
      .q_stopped(q_stopped), .q_err(q_err)
   );

   // descriptor memory model, one cycle read latency
   logic [16:0] dram [0:MR-1];
   always @(posedge clk) if (rd_en) rd_data <= dram[rd_addr];

   typedef struct { int start; int cnt; int len; } pexp_t;
   typedef struct { int addr; logic [127:0] data; } cexp_t;
   pexp_t pq[$];
   cexp_t cq_q[$];
   pexp_t me;
   cexp_t mc;

   int n_chk = 0, n_err = 0;
   int seen_pkts = 0, seen_cmps = 0, rd_seen = 0;
   int exp_pkts = 0, exp_cmps = 0;
   int h_idx = 0, h_cidx = 0;
   bit h_gen = 1'b1, h_cgen = 1'b1;
   bit fin = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected items as the design produces results
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_en) rd_seen++;
         if (pkt_valid) begin
            seen_pkts++;
            if (pq.size() == 0) chk(1'b0, "R4", "unexpected packet at", longint'(pkt_start), -1);
            else begin
               me = pq.pop_front();
               chk(int'(pkt_start) == me.start, "R4", "packet start", longint'(pkt_start), me.start);
               chk(int'(pkt_cnt) == me.cnt, "R4", "packet count", longint'(pkt_cnt), me.cnt);
               chk(int'(pkt_len) == me.len, "R4", "packet length", longint'(pkt_len), me.len);
            end
         end
         if (cmp_we) begin
            seen_cmps++;
            if (cq_q.size() == 0) chk(1'b0, "R6", "unexpected completion at", longint'(cmp_addr), -1);
            else begin
               mc = cq_q.pop_front();
               // R7: address and lap bit follow the completion ring
               chk(int'(cmp_addr) == mc.addr, "R7", "completion slot", longint'(cmp_addr), mc.addr);
               chk(cmp_data[63:0] == mc.data[63:0], "R6", "record low half",
                   longint'(cmp_data[63:0]), longint'(mc.data[63:0]));
               chk(cmp_data[127:64] == mc.data[127:64], "R6", "record high half",
                   longint'(cmp_data[127:64]), longint'(mc.data[127:64]));
            end
         end
      end
   end

   task automatic put_desc(input int l, input bit e, input bit c, input bit g);
      dram[h_idx] = {c, e, g, 14'(l)};
      h_idx++;
      if (h_idx == TXR) begin h_idx = 0; h_gen = ~h_gen; end
   endtask

   task automatic set_prod(input int p);
      @(negedge clk);
      prod_idx = IDX_W'(p);
      prod_we  = 1'b1;
      @(negedge clk);
      prod_we  = 1'b0;
   endtask

   // driver: writes a packet, pushes its expected summary and completion
   task automatic send_pkt(input int n, input int base, input bit cq);
      pexp_t e;
      cexp_t c;
      int last_idx;
      e.start = h_idx; e.cnt = n; e.len = 0;
      last_idx = 0;
      for (int i = 0; i < n; i++) begin
         int l;
         l = (base + i * 1000) % 16384;
         e.len += (l == 0) ? 16384 : l;
         if (i == n - 1) last_idx = h_idx;
         put_desc(l, i == n - 1, cq && (i == n - 1), h_gen);
      end
      pq.push_back(e);
      exp_pkts++;
      if (cq) begin
         c.addr = h_cidx;
         c.data = {h_cgen, 7'd0, 24'd0, 64'd0, 20'd0, 12'(last_idx)};
         cq_q.push_back(c);
         exp_cmps++;
         h_cidx++;
         if (h_cidx == CMR) begin h_cidx = 0; h_cgen = ~h_cgen; end
      end
      set_prod(h_idx);
   endtask

   task automatic drain(input string req);
      int t;
      t = 0;
      while ((pq.size() != 0 || cq_q.size() != 0) && t < 500) begin
         @(negedge clk);
         t++;
      end
      repeat (4) @(negedge clk);
      chk(pq.size() == 0 && cq_q.size() == 0, req, "outstanding expected items",
          pq.size() + cq_q.size(), 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      prod_we = 1'b0;
      prod_idx = '0;
      pq.delete();
      cq_q.delete();
      h_idx = 0; h_gen = 1'b1; h_cidx = 0; h_cgen = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic chk_reset_state();
      chk(!pkt_valid, "R1", "pkt_valid after reset", longint'(pkt_valid), 0);
      chk(!cmp_we, "R1", "cmp_we after reset", longint'(cmp_we), 0);
      chk(!rd_en, "R1", "rd_en after reset", longint'(rd_en), 0);
      chk(!q_stopped, "R1", "q_stopped after reset", longint'(q_stopped), 0);
      chk(q_err == 32'd0, "R1", "q_err after reset", longint'(q_err), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MR; i++) dram[i] = '0;
      do_reset();
      chk_reset_state();

      // R2: single descriptor with completion request
      send_pkt(1, 100, 1'b1);
      drain("R2");
      // R4: zero length counts as the full buffer size
      send_pkt(3, 0, 1'b1);
      drain("R4");
      // R6: no completion request, no record
      send_pkt(2, 700, 1'b0);
      drain("R6");
      // R8: exactly MAX_DESC descriptors is legal
      send_pkt(16, 500, 1'b1);
      drain("R8");
      chk(!q_stopped, "R8", "halt on a 16-descriptor packet", longint'(q_stopped), 0);

      // R3: packet split across two producer updates waits
      begin
         pexp_t e;
         cexp_t c;
         int s0;
         s0 = seen_pkts;
         e.start = h_idx; e.cnt = 3; e.len = 300 + 400 + 500;
         put_desc(300, 1'b0, 1'b0, h_gen);
         put_desc(400, 1'b0, 1'b0, h_gen);
         set_prod(h_idx);
         repeat (30) @(negedge clk);
         chk(seen_pkts == s0, "R3", "summary before closing descriptor", seen_pkts - s0, 0);
         chk(!q_stopped, "R3", "halt while waiting", longint'(q_stopped), 0);
         c.addr = h_cidx;
         c.data = {h_cgen, 7'd0, 24'd0, 64'd0, 20'd0, 12'(h_idx)};
         put_desc(500, 1'b1, 1'b1, h_gen);
         pq.push_back(e); exp_pkts++;
         cq_q.push_back(c); exp_cmps++;
         h_cidx++;
         set_prod(h_idx);
         drain("R3");
      end

      // R11: stale slot with no open packet is polled, not an error
      begin
         pexp_t e;
         int s0, slot;
         s0 = seen_pkts;
         slot = h_idx;
         dram[slot] = {1'b0, 1'b1, ~h_gen, 14'd77};
         set_prod((slot + 1) % TXR);
         repeat (30) @(negedge clk);
         chk(!q_stopped, "R11", "halt on stale idle slot", longint'(q_stopped), 0);
         chk(seen_pkts == s0, "R11", "summary from stale slot", seen_pkts - s0, 0);
         e.start = slot; e.cnt = 1; e.len = 50;
         pq.push_back(e); exp_pkts++;
         put_desc(50, 1'b1, 1'b0, h_gen);
         drain("R11");
      end

      // R5 and R7: many packets wrap both rings
      for (int i = 0; i < 90; i++) begin
         send_pkt(i % 2 + 1, (i * 37) % 16384, (i % 7) != 0);
         drain("R5");
      end
      chk(seen_pkts == exp_pkts, "R5", "packets across ring wraps", seen_pkts, exp_pkts);
      chk(seen_cmps == exp_cmps, "R7", "completions across ring wraps", seen_cmps, exp_cmps);
      chk(!q_stopped, "R5", "halt across ring wraps", longint'(q_stopped), 0);

      // R9: chain breaks inside an open packet
      do_reset();
      begin
         int s0, r0;
         s0 = seen_pkts;
         put_desc(10, 1'b0, 1'b0, h_gen);
         dram[h_idx] = {1'b0, 1'b1, ~h_gen, 14'd20};
         set_prod(h_idx + 1);
         repeat (20) @(negedge clk);
         chk(q_stopped, "R9", "halted", longint'(q_stopped), 1);
         chk(q_err == 32'h8000_0000, "R9", "error code", longint'(q_err), 32'h8000_0000);
         chk(seen_pkts == s0, "R9", "summary on broken chain", seen_pkts - s0, 0);
         // R10: producer updates ignored while halted
         r0 = rd_seen;
         dram[2] = {1'b0, 1'b1, 1'b1, 14'd30};
         set_prod(3);
         repeat (30) @(negedge clk);
         chk(rd_seen == r0, "R10", "reads while halted", rd_seen - r0, 0);
         chk(seen_pkts == s0, "R10", "summary while halted", seen_pkts - s0, 0);
         chk(q_stopped, "R10", "still halted", longint'(q_stopped), 1);
         chk(q_err == 32'h8000_0000, "R10", "code held", longint'(q_err), 32'h8000_0000);
      end

      // R8: too many descriptors
      do_reset();
      chk_reset_state();
      begin
         int s0;
         s0 = seen_pkts;
         for (int i = 0; i < 17; i++) put_desc(100, 1'b0, 1'b0, h_gen);
         set_prod(h_idx);
         repeat (80) @(negedge clk);
         chk(q_stopped, "R8", "halted", longint'(q_stopped), 1);
         chk(q_err == 32'h8000_0002, "R8", "error code", longint'(q_err), 32'h8000_0002);
         chk(seen_pkts == s0, "R8", "summary for oversized packet", seen_pkts - s0, 0);
      end

      fin = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule